// File: doc/BRIEF.md
# Line-Repeat Read Sequencer

This block sits next to the read port of a field memory in a scan converter. Once per output line it chooses how the memory read pointer moves before that line is read. It can hold the pointer, which rewinds to the start of the current stored line so that line is replayed. It can increment the pointer, which advances to the start of the next stored line. At the start of each output field it resets the pointer to the first stored line.

The repetition pattern depends on a mode that is sampled at vertical sync:
- **Pass-through** advances on every line.
- **Line doubling** shows every stored line twice, to turn interlaced fields into progressive frames. The field parity flag picks whether the repeated copy comes before or after the advance, which keeps the two fields vertically centred.
- **Enlargement** alternates one hold and then two holds between advances. This gives five output lines for every two stored lines.

The block has no memory and no pixel timing. It only issues the repositioning pulses.

Top module: `line_repeat_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, all three command outputs are low. Out of reset the active mode is pass-through until the first vertical sync.
- R2: A `vsync` pulse sampled at a clock edge gives a `fld_rst` pulse exactly one clock wide in the following cycle. A `line_stb` sampled in the same cycle as `vsync` produces no line command.
- R3: Every `line_stb` sampled without `vsync` gives exactly one pulse, on either `line_hold` or `line_inc`, in the following cycle. That pulse is one clock wide. No command pulse appears without a strobe or sync.
- R4: In pass-through mode (`mode_sel` = 0), every line command is `line_inc`.
- R5: In line-doubling mode (`mode_sel` = 1) with `field_odd` = 0, the lines of a field receive inc, hold, inc, hold and so on. With `field_odd` = 1 they receive hold, inc, hold, inc and so on.
- R6: In enlargement mode (`mode_sel` = 2), the lines after each field reset receive the repeating sequence inc, hold, inc, hold, hold. The sequence restarts from its first entry at every field reset.
- R7: `mode_sel` and `field_odd` are sampled only in a cycle with `vsync` high. Changes between syncs have no effect until the next sync.
- R8: The unused code `mode_sel` = 3 behaves as pass-through.
- R9: Over whole pattern periods, enlargement yields five output lines per two increments. Line doubling yields two output lines per increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_stb | input | 1 | One-cycle pulse per output line |
| vsync | input | 1 | One-cycle pulse at the start of an output field |
| mode_sel | input | 2 | 0 pass-through, 1 line doubling, 2 enlargement, 3 as 0 |
| field_odd | input | 1 | Parity of the incoming field (1 = odd) |
| fld_rst | output | 1 | Pulse: move the read pointer to the first stored line |
| line_hold | output | 1 | Pulse: rewind the read pointer to the start of the current line |
| line_inc | output | 1 | Pulse: advance the read pointer to the start of the next line |

## Verification
Each mode is driven over fields longer than its pattern period, so that a wrong phase wrap or a missing restart shows up as a misplaced hold.

Line doubling is run with both parities. This separates a design that ignores the flag from one that inverts it.

Enlargement is run across two field resets. This shows whether the five-line pattern restarts at each field reset or runs on from the previous field.

Further runs change the mode and parity inputs in the middle of a field, put a strobe in the same cycle as a sync, and select the unused mode code. These show, in turn, whether the inputs are sampled only at sync, whether a sync suppresses the line command, and whether the unused code is treated as pass-through.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

    typedef enum logic [1:0] {
        MD_PASS    = 2'd0,
        MD_DOUBLE  = 2'd1,
        MD_ENLARGE = 2'd2,
        MD_SPARE   = 2'd3
    } scan_mode_e;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_HOLD = 2'd1,
        CMD_INC  = 2'd2
    } line_cmd_e;

    // pattern lengths in output lines
    localparam int unsigned DBL_LEN = 2;
    localparam int unsigned ENL_LEN = 5;
    localparam int unsigned PH_W    = $clog2(ENL_LEN);

    typedef logic [PH_W-1:0] phase_t;

    // last phase value before wrap, per mode
    function automatic phase_t phase_last(scan_mode_e m);
        case (m)
            MD_DOUBLE:  return phase_t'(DBL_LEN - 1);
            MD_ENLARGE: return phase_t'(ENL_LEN - 1);
            default:    return '0;
        endcase
    endfunction

    // command for a line at a given phase
    function automatic line_cmd_e pick_cmd(scan_mode_e m, logic odd, phase_t ph);
        case (m)
            MD_DOUBLE:  return ((ph == '0) ^ odd) ? CMD_INC : CMD_HOLD;
            MD_ENLARGE: return (ph == phase_t'(0) || ph == phase_t'(2)) ? CMD_INC : CMD_HOLD;
            default:    return CMD_INC;
        endcase
    endfunction

endpackage

// File: rtl/lrs_field_latch.sv
module lrs_field_latch
    import lrs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       vsync,
    input  logic [1:0] mode_in,
    input  logic       odd_in,
    output scan_mode_e mode_q,
    output logic       odd_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MD_PASS;
            odd_q  <= 1'b0;
        end else if (vsync) begin
            mode_q <= scan_mode_e'(mode_in);
            odd_q  <= odd_in;
        end
    end
endmodule

// File: rtl/lrs_phase_ctr.sv
module lrs_phase_ctr
    import lrs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       vsync,
    input  logic       line_stb,
    input  scan_mode_e mode_q,
    output phase_t     ph
);
    phase_t last;

    always_comb last = phase_last(mode_q);

    always_ff @(posedge clk) begin
        if (rst || vsync) begin
            ph <= '0;
        end else if (line_stb) begin
            ph <= (ph >= last) ? '0 : ph + phase_t'(1);
        end
    end
endmodule

// File: rtl/lrs_cmd_issue.sv
module lrs_cmd_issue
    import lrs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       vsync,
    input  logic       line_stb,
    input  scan_mode_e mode_q,
    input  logic       odd_q,
    input  phase_t     ph,
    output logic       fld_rst,
    output logic       line_hold,
    output logic       line_inc
);
    line_cmd_e cmd;

    always_comb begin
        cmd = CMD_NONE;
        if (line_stb && !vsync) cmd = pick_cmd(mode_q, odd_q, ph);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fld_rst   <= 1'b0;
            line_hold <= 1'b0;
            line_inc  <= 1'b0;
        end else begin
            fld_rst   <= vsync;
            line_hold <= (cmd == CMD_HOLD);
            line_inc  <= (cmd == CMD_INC);
        end
    end
endmodule

// File: rtl/line_repeat_seq.sv
module line_repeat_seq
    import lrs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       line_stb,
    input  logic       vsync,
    input  logic [1:0] mode_sel,
    input  logic       field_odd,
    output logic       fld_rst,
    output logic       line_hold,
    output logic       line_inc
);
    scan_mode_e mode_q;
    logic       odd_q;
    phase_t     ph;

    lrs_field_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .vsync   (vsync),
        .mode_in (mode_sel),
        .odd_in  (field_odd),
        .mode_q  (mode_q),
        .odd_q   (odd_q)
    );

    lrs_phase_ctr u_phase (
        .clk      (clk),
        .rst      (rst),
        .vsync    (vsync),
        .line_stb (line_stb),
        .mode_q   (mode_q),
        .ph       (ph)
    );

    lrs_cmd_issue u_issue (
        .clk       (clk),
        .rst       (rst),
        .vsync     (vsync),
        .line_stb  (line_stb),
        .mode_q    (mode_q),
        .odd_q     (odd_q),
        .ph        (ph),
        .fld_rst   (fld_rst),
        .line_hold (line_hold),
        .line_inc  (line_inc)
    );
endmodule

// File: rtl/lrs_checker.sv
module lrs_checker (
    input logic       clk,
    input logic       rst,
    input logic       line_stb,
    input logic       vsync,
    input logic [1:0] mode_sel,
    input logic       fld_rst,
    input logic       line_hold,
    input logic       line_inc
);
    AST_ONE_CMD: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fld_rst, line_hold, line_inc})) else $error("one cmd"); // R3

    AST_FRST_FOLLOWS_VS: assert property (@(posedge clk) disable iff (rst)
        vsync |=> (fld_rst && !line_hold && !line_inc)) else $error("frst"); // R2

    AST_FRST_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (fld_rst && !$past(vsync)) |-> 1'b0) else $error("frst width"); // R2

    AST_LINE_PER_STB: assert property (@(posedge clk) disable iff (rst)
        (line_stb && !vsync) |=> (line_hold || line_inc)) else $error("stb"); // R3

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        (!line_stb || vsync) |=> (!line_hold && !line_inc)) else $error("spurious"); // R3
endmodule

bind line_repeat_seq lrs_checker i_lrs_checker (
    .clk       (clk),
    .rst       (rst),
    .line_stb  (line_stb),
    .vsync     (vsync),
    .mode_sel  (mode_sel),
    .fld_rst   (fld_rst),
    .line_hold (line_hold),
    .line_inc  (line_inc)
);

// File: tb/test_line_repeat_seq.sv
`timescale 1ns/1ps
module test_line_repeat_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_stb = 1'b0;
    logic       vsync = 1'b0;
    logic [1:0] mode_sel = 2'd0;
    logic       field_odd = 1'b0;
    logic       fld_rst, line_hold, line_inc;

    always #5 clk = ~clk;

    line_repeat_seq i_line_repeat_seq (
        .clk(clk), .rst(rst), .line_stb(line_stb), .vsync(vsync),
        .mode_sel(mode_sel), .field_odd(field_odd),
        .fld_rst(fld_rst), .line_hold(line_hold), .line_inc(line_inc)
    );

    // codes: 100 field reset, 010 hold, 001 increment
    logic [2:0] exp_q[$];
    string      tag_q[$];
    int total = 0;
    int bad = 0;
    int n_inc = 0;
    int n_line = 0;
    int cyc = 0;
    int m_mode = 0;
    int m_odd = 0;
    int m_ln = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [2:0] model_cmd();
        int p;
        case (m_mode)
            1: begin
                p = m_ln % 2;
                return ((p == 0) ^ (m_odd != 0)) ? 3'b001 : 3'b010;
            end
            2: begin
                p = m_ln % 5;
                return (p == 0 || p == 2) ? 3'b001 : 3'b010;
            end
            default: return 3'b001;
        endcase
    endfunction

    task automatic do_line(input string req);
        @(negedge clk);
        exp_q.push_back(model_cmd());
        tag_q.push_back(req);
        m_ln++;
        line_stb = 1'b1;
        @(negedge clk);
        line_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_vsync(input int m, input int o, input bit with_stb);
        @(negedge clk);
        mode_sel  = 2'(m);
        field_odd = o[0];
        vsync     = 1'b1;
        line_stb  = with_stb;
        exp_q.push_back(3'b100);
        tag_q.push_back("R2");
        @(negedge clk);
        vsync    = 1'b0;
        line_stb = 1'b0;
        m_mode = m;
        m_odd  = o;
        m_ln   = 0;
        @(negedge clk);
    endtask

    // monitor: pops expected items as pulses appear
    always @(negedge clk) begin
        logic [2:0] act;
        if (!rst && !done) begin
            act = {fld_rst, line_hold, line_inc};
            if (act != 3'b000) begin
                if (line_inc) n_inc++;
                if (line_hold || line_inc) n_line++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3", int'(act), 0);
                end else begin
                    logic [2:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(act == e, t, int'(act), int'(e));
                end
            end
        end
    end

    task automatic finish_run();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            check(1'b0, "watchdog", cyc, 0);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check({fld_rst, line_hold, line_inc} == 3'b000, "R1", int'({fld_rst, line_hold, line_inc}), 0);
        rst = 1'b0;
        @(negedge clk);
        check({fld_rst, line_hold, line_inc} == 3'b000, "R1", int'({fld_rst, line_hold, line_inc}), 0);
        // default mode before any sync is pass-through
        mode_sel = 2'd2;
        for (int i = 0; i < 3; i++) do_line("R1");

        do_vsync(0, 0, 0);
        for (int i = 0; i < 4; i++) do_line("R4");

        // R5 even parity, with ratio check R9
        do_vsync(1, 0, 0);
        n_inc = 0; n_line = 0;
        for (int i = 0; i < 8; i++) do_line("R5");
        @(negedge clk);
        check(n_inc == 4 && n_line == 8, "R9", n_inc, 4);

        do_vsync(1, 1, 0);
        for (int i = 0; i < 6; i++) do_line("R5");

        // R6 enlargement, two fields to see the restart
        do_vsync(2, 0, 0);
        n_inc = 0; n_line = 0;
        for (int i = 0; i < 10; i++) do_line("R6");
        @(negedge clk);
        check(n_inc == 4 && n_line == 10, "R9", n_inc, 4);
        for (int i = 0; i < 2; i++) do_line("R6");
        do_vsync(2, 1, 0);
        for (int i = 0; i < 7; i++) do_line("R6");

        // R7 inputs changed mid-field are ignored
        do_vsync(1, 0, 0);
        mode_sel = 2'd2; field_odd = 1'b1;
        for (int i = 0; i < 5; i++) do_line("R7");

        // R2 strobe together with sync gives only the field reset
        do_vsync(2, 0, 1);
        for (int i = 0; i < 3; i++) do_line("R2");

        do_vsync(3, 1, 0);
        for (int i = 0; i < 4; i++) do_line("R8");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R3", exp_q.size(), 0);
        finish_run();
    end
endmodule